// File: doc/BRIEF.md
# Opcode-group-5 ModR/M decoder

This block is one decode stage in the front end of a processor running in 64-bit mode. It takes instruction bytes one at a time over a valid/ready handshake. It waits for the group opcode byte 0xFF and then reads the ModR/M byte that follows. When the ModR/M byte calls for one, it also reads a SIB byte. It then consumes the displacement bytes that the addressing form requires. Only after the last byte of the instruction has been taken does it present one decoded result to the downstream stage.

The operation is chosen by the middle three bits of the ModR/M byte, not by the opcode. Along with the operation, the result gives the operand size, whether the operand sits in a register or in memory, whether a SIB byte was present, the displacement length and the total instruction length. Encodings that have no meaning are raised on an invalid flag. The displacement bytes are counted and dropped; their values are not reported. A displacement byte that happens to equal 0xFF is therefore never taken for the start of a new instruction.

Top module: `g5_decoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: While waiting for an opcode, any accepted byte other than 0xFF is dropped and produces no result.
- R3: out_op equals ModR/M bits 5:3 of the instruction: 0 increment, 1 decrement, 2 near indirect call, 3 far indirect call, 4 near indirect jump, 5 far indirect jump, 6 push, 7 reserved.
- R4: The byte sequence FF 25 followed by four displacement bytes reports out_op 4 (near indirect jump), memory operand, no SIB, displacement length 4 and total length 6.
- R5: out_size64 is 1 for near call, near jump and push, whatever the value of rex_w. For every other operation it equals rex_w as sampled with the 0xFF byte.
- R6: out_is_mem is 0 exactly when ModR/M bits 7:6 are 11.
- R7: A SIB byte is consumed, and out_has_sib is 1, exactly when ModR/M bits 2:0 are 100 and bits 7:6 are not 11.
- R8: out_disp_len is set as follows:
  - 1 for mod 01.
  - 4 for mod 10.
  - 4 for mod 00 with r/m 101 (instruction-pointer-relative).
  - 4 for mod 00 with a SIB byte whose bits 2:0 are 101.
  - 0 in every other case.
- R9: out_len equals 2 + out_has_sib + out_disp_len. The decoder accepts exactly that many bytes for the instruction, so a displacement byte of 0xFF is not treated as an opcode.
- R10: out_illegal is 1 when out_op is 7. It is also 1 when out_op is 3 or 5 with mod 11. It is 0 otherwise.
- R11: While out_valid is 1 and out_ready is 0, in_ready is 0 and every result output holds its value.
- R12: In the cycle after a result is accepted, out_valid is 0. A byte offered during the accepting cycle is taken in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction byte is offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | The decoder takes the offered byte this cycle |
| rex_w | input | 1 | Operand-width prefix flag, sampled with the 0xFF byte |
| out_valid | output | 1 | A decoded result is presented |
| out_ready | input | 1 | Downstream accepts the result |
| out_op | output | 3 | Operation code (ModR/M bits 5:3) |
| out_size64 | output | 1 | Operand size is 64 bits |
| out_is_mem | output | 1 | Operand is in memory |
| out_has_sib | output | 1 | A SIB byte was present |
| out_disp_len | output | 3 | Displacement length in bytes (0, 1 or 4) |
| out_len | output | 4 | Total instruction length in bytes |
| out_illegal | output | 1 | Invalid-opcode condition |

## Verification
Two events can land on the same clock edge. One is the hand-off of a finished result. The other is a new 0xFF byte arriving from upstream while the decoder is stalled. To provoke this, the bench holds out_ready low with the next opcode byte already waiting on the input, then releases out_ready. The bench then checks three things. In the cycle after the release, out_valid must be low. The waiting byte must still be offered and not yet taken. When the following instruction completes, it must decode correctly, which shows that the byte was neither lost nor taken twice.

// File: rtl/g5_pkg.sv
// Shared types and constants for the opcode-group-5 decoder.
// Assumes 64-bit mode with no operand-size or address-size prefixes.
package g5_pkg;

    localparam int BYTE_W = 8;

    // Operation codes: the value is the ModR/M reg field itself.
    typedef enum logic [2:0] {
        OP_INC       = 3'd0,
        OP_DEC       = 3'd1,
        OP_CALL_NEAR = 3'd2,
        OP_CALL_FAR  = 3'd3,
        OP_JMP_NEAR  = 3'd4,
        OP_JMP_FAR   = 3'd5,
        OP_PUSH      = 3'd6,
        OP_RSVD      = 3'd7
    } g5_op_e;

    // Byte-collection states.
    typedef enum logic [2:0] {
        ST_OPC    = 3'd0,
        ST_MODRM  = 3'd1,
        ST_SIB    = 3'd2,
        ST_DISP   = 3'd3,
        ST_REPORT = 3'd4
    } g5_state_e;

    // ModR/M field codes that the address-form rules depend on.
    localparam logic [1:0] MOD_MEM0  = 2'b00;
    localparam logic [1:0] MOD_MEM8  = 2'b01;
    localparam logic [1:0] MOD_MEM32 = 2'b10;
    localparam logic [1:0] MOD_REG   = 2'b11;
    localparam logic [2:0] RM_SIB    = 3'b100;
    localparam logic [2:0] RM_NOBASE = 3'b101;

    // Displacement sizes in bytes.
    localparam int DISP_SHORT = 1;
    localparam int DISP_LONG  = 4;
    // Opcode byte plus ModR/M byte.
    localparam int BASE_LEN   = 2;

endpackage

// File: rtl/g5_addr_form.sv
// Addressing-form classifier for one ModR/M byte and an optional SIB byte.
// Purely combinational. The SIB input is ignored unless the ModR/M byte
// calls for a SIB byte.
module g5_addr_form
    import g5_pkg::*;
#(
    parameter int LEN_W  = 4,
    parameter int DLEN_W = 3
) (
    input  logic [BYTE_W-1:0] modrm,
    input  logic [BYTE_W-1:0] sib,
    output logic              is_mem,
    output logic              needs_sib,
    output logic [DLEN_W-1:0] disp_len,
    output logic [LEN_W-1:0]  total_len
);

    logic [1:0] mod_f;
    logic [2:0] rm_f;
    logic [2:0] base_f;

    // Split the fields that the rules look at.
    always_comb begin
        mod_f  = modrm[7:6];
        rm_f   = modrm[2:0];
        base_f = sib[2:0];
    end

    // Register versus memory operand, and presence of a SIB byte.
    always_comb begin
        is_mem    = (mod_f != MOD_REG);
        needs_sib = is_mem && (rm_f == RM_SIB);
    end

    // Displacement size in 64-bit mode.
    always_comb begin
        case (mod_f)
            MOD_MEM8:  disp_len = DLEN_W'(DISP_SHORT);
            MOD_MEM32: disp_len = DLEN_W'(DISP_LONG);
            MOD_MEM0: begin
                if (rm_f == RM_NOBASE)
                    disp_len = DLEN_W'(DISP_LONG);
                else if (rm_f == RM_SIB && base_f == RM_NOBASE)
                    disp_len = DLEN_W'(DISP_LONG);
                else
                    disp_len = '0;
            end
            default:   disp_len = '0;
        endcase
    end

    // Total length: opcode, ModR/M, optional SIB, then the displacement.
    always_comb begin
        total_len = LEN_W'(BASE_LEN) + LEN_W'(needs_sib) + LEN_W'(disp_len);
    end

endmodule

// File: rtl/g5_op_class.sv
// Operation classifier for the 0xFF group: reg field to operation,
// operand size and invalid-encoding flag. Purely combinational.
// Assumes 64-bit mode, where near branches and push are always 64 bits wide.
module g5_op_class
    import g5_pkg::*;
(
    input  logic [BYTE_W-1:0] modrm,
    input  logic              rex_w,
    output g5_op_e            op,
    output logic              size64,
    output logic              illegal
);

    logic reg_form;

    // The operation is selected by ModR/M bits 5:3.
    always_comb begin
        op       = g5_op_e'(modrm[5:3]);
        reg_form = (modrm[7:6] == MOD_REG);
    end

    // Operand size: forced to 64 bits for stack and near-branch forms.
    always_comb begin
        case (op)
            OP_CALL_NEAR, OP_JMP_NEAR, OP_PUSH: size64 = 1'b1;
            default:                            size64 = rex_w;
        endcase
    end

    // Invalid: the reserved slot, and far forms that name a register.
    always_comb begin
        case (op)
            OP_RSVD:                 illegal = 1'b1;
            OP_CALL_FAR, OP_JMP_FAR: illegal = reg_form;
            default:                 illegal = 1'b0;
        endcase
    end

endmodule

// File: rtl/g5_byte_seq.sv
// Byte sequencer: walks opcode, ModR/M, optional SIB and displacement bytes,
// then presents one result until it is accepted. It takes no byte while a
// result is pending. The view outputs select the incoming byte while that
// byte is being read, and the stored copy otherwise. This lets the
// classifiers decide the next step in the same cycle the byte arrives.
module g5_byte_seq
    import g5_pkg::*;
#(
    parameter logic [BYTE_W-1:0] GROUP_OPC = 8'hFF,
    parameter int                DLEN_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    input  logic              rex_w,
    input  logic              needs_sib,
    input  logic [DLEN_W-1:0] disp_len,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] modrm_view,
    output logic [BYTE_W-1:0] sib_view,
    output logic [BYTE_W-1:0] modrm_q,
    output logic              rex_q
);

    g5_state_e         state_q, state_d;
    logic [DLEN_W-1:0] cnt_q, cnt_d;
    logic [BYTE_W-1:0] sib_q;
    logic              take;

    // Handshake on both edges of the stage.
    always_comb begin
        in_ready  = (state_q != ST_REPORT);
        out_valid = (state_q == ST_REPORT);
        take      = in_valid && in_ready;
    end

    // Feed the classifiers with the byte being read, or the stored copy.
    always_comb begin
        modrm_view = (state_q == ST_MODRM) ? in_byte : modrm_q;
        sib_view   = (state_q == ST_SIB)   ? in_byte : sib_q;
    end

    // Next state and displacement count.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            ST_OPC: begin
                if (take && in_byte == GROUP_OPC)
                    state_d = ST_MODRM;
            end
            ST_MODRM: begin
                if (take) begin
                    if (needs_sib) begin
                        state_d = ST_SIB;
                    end else if (disp_len != '0) begin
                        state_d = ST_DISP;
                        cnt_d   = disp_len;
                    end else begin
                        state_d = ST_REPORT;
                    end
                end
            end
            ST_SIB: begin
                if (take) begin
                    if (disp_len != '0) begin
                        state_d = ST_DISP;
                        cnt_d   = disp_len;
                    end else begin
                        state_d = ST_REPORT;
                    end
                end
            end
            ST_DISP: begin
                if (take) begin
                    cnt_d = cnt_q - DLEN_W'(1);
                    if (cnt_q == DLEN_W'(1))
                        state_d = ST_REPORT;
                end
            end
            ST_REPORT: begin
                if (out_ready)
                    state_d = ST_OPC;
            end
            default: state_d = ST_OPC;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPC;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Capture the prefix flag, the ModR/M byte and the SIB byte as they pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modrm_q <= '0;
            sib_q   <= '0;
            rex_q   <= 1'b0;
        end else if (take) begin
            if (state_q == ST_OPC && in_byte == GROUP_OPC)
                rex_q <= rex_w;
            if (state_q == ST_MODRM) begin
                modrm_q <= in_byte;
                sib_q   <= '0;
            end
            if (state_q == ST_SIB)
                sib_q <= in_byte;
        end
    end

endmodule

// File: rtl/g5_decoder.sv
// Top of the opcode-group-5 decoder. Connects the byte sequencer to the
// addressing-form and operation classifiers. All result outputs come from
// registered bytes, so they stay still while a result waits for out_ready.
module g5_decoder
    import g5_pkg::*;
#(
    parameter logic [7:0] GROUP_OPC = 8'hFF,
    parameter int         LEN_W     = 4,
    parameter int         DLEN_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    input  logic             rex_w,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [2:0]       out_op,
    output logic             out_size64,
    output logic             out_is_mem,
    output logic             out_has_sib,
    output logic [DLEN_W-1:0] out_disp_len,
    output logic [LEN_W-1:0] out_len,
    output logic             out_illegal
);

    logic [BYTE_W-1:0] modrm_view;
    logic [BYTE_W-1:0] sib_view;
    logic [BYTE_W-1:0] modrm_q;
    logic              rex_q;
    logic              needs_sib;
    logic [DLEN_W-1:0] disp_len;
    logic              is_mem;
    logic [LEN_W-1:0]  total_len;
    g5_op_e            op;

    g5_byte_seq #(.GROUP_OPC(GROUP_OPC), .DLEN_W(DLEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .in_ready   (in_ready),
        .rex_w      (rex_w),
        .needs_sib  (needs_sib),
        .disp_len   (disp_len),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .modrm_view (modrm_view),
        .sib_view   (sib_view),
        .modrm_q    (modrm_q),
        .rex_q      (rex_q)
    );

    g5_addr_form #(.LEN_W(LEN_W), .DLEN_W(DLEN_W)) u_addr (
        .modrm     (modrm_view),
        .sib       (sib_view),
        .is_mem    (is_mem),
        .needs_sib (needs_sib),
        .disp_len  (disp_len),
        .total_len (total_len)
    );

    g5_op_class u_op (
        .modrm   (modrm_q),
        .rex_w   (rex_q),
        .op      (op),
        .size64  (out_size64),
        .illegal (out_illegal)
    );

    // Drive the result outputs.
    always_comb begin
        out_op       = op;
        out_is_mem   = is_mem;
        out_has_sib  = needs_sib;
        out_disp_len = disp_len;
        out_len      = total_len;
    end

endmodule

// File: rtl/g5_decode_chk.sv
// Property checker for g5_decoder, attached with bind.
module g5_decode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [2:0] out_op,
    input logic       out_size64,
    input logic       out_is_mem,
    input logic       out_has_sib,
    input logic [2:0] out_disp_len,
    input logic [3:0] out_len,
    input logic       out_illegal
);

    // R11
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R11
    stall_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_len)
            && $stable(out_size64) && $stable(out_illegal)));

    // R12
    result_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);

    // R9
    length_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len == 4'd2 + 4'(out_has_sib) + 4'(out_disp_len)));

    // R6
    reg_operand_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_mem) |-> (!out_has_sib && out_disp_len == 3'd0));

    // R5
    forced_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_op == 3'd2 || out_op == 3'd4 || out_op == 3'd6)) |-> out_size64);

    // R10
    reserved_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_op == 3'd7) |-> out_illegal);

endmodule

bind g5_decoder g5_decode_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_op       (out_op),
    .out_size64   (out_size64),
    .out_is_mem   (out_is_mem),
    .out_has_sib  (out_has_sib),
    .out_disp_len (out_disp_len),
    .out_len      (out_len),
    .out_illegal  (out_illegal)
);

// File: tb/sim_g5_decoder.sv
module sim_g5_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready;
    logic       rex_w = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [2:0] out_op;
    logic       out_size64;
    logic       out_is_mem;
    logic       out_has_sib;
    logic [2:0] out_disp_len;
    logic [3:0] out_len;
    logic       out_illegal;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    g5_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .rex_w(rex_w), .out_valid(out_valid),
        .out_ready(out_ready), .out_op(out_op), .out_size64(out_size64),
        .out_is_mem(out_is_mem), .out_has_sib(out_has_sib),
        .out_disp_len(out_disp_len), .out_len(out_len), .out_illegal(out_illegal)
    );

    // Vector: rex, modrm, sib | op, size64, mem, sib, disp, len, illegal
    localparam int NV = 16;
    localparam logic [30:0] VEC [NV] = '{
        {1'b0, 8'h25, 8'h00, 3'd4, 1'b1, 1'b1, 1'b0, 3'd4, 4'd6, 1'b0}, // R4 FF 25
        {1'b1, 8'hE0, 8'h00, 3'd4, 1'b1, 1'b0, 1'b0, 3'd0, 4'd2, 1'b0},
        {1'b0, 8'hC0, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 4'd2, 1'b0},
        {1'b1, 8'hC8, 8'h00, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 4'd2, 1'b0},
        {1'b0, 8'h14, 8'h24, 3'd2, 1'b1, 1'b1, 1'b1, 3'd0, 4'd3, 1'b0},
        {1'b0, 8'h14, 8'h25, 3'd2, 1'b1, 1'b1, 1'b1, 3'd4, 4'd7, 1'b0},
        {1'b1, 8'h5C, 8'h00, 3'd3, 1'b1, 1'b1, 1'b1, 3'd1, 4'd4, 1'b0},
        {1'b0, 8'h98, 8'h00, 3'd3, 1'b0, 1'b1, 1'b0, 3'd4, 4'd6, 1'b0},
        {1'b0, 8'hD8, 8'h00, 3'd3, 1'b0, 1'b0, 1'b0, 3'd0, 4'd2, 1'b1},
        {1'b1, 8'hE8, 8'h00, 3'd5, 1'b1, 1'b0, 1'b0, 3'd0, 4'd2, 1'b1},
        {1'b0, 8'h6D, 8'h00, 3'd5, 1'b0, 1'b1, 1'b0, 3'd1, 4'd3, 1'b0},
        {1'b0, 8'h75, 8'h00, 3'd6, 1'b1, 1'b1, 1'b0, 3'd1, 4'd3, 1'b0},
        {1'b0, 8'h38, 8'h00, 3'd7, 1'b0, 1'b1, 1'b0, 3'd0, 4'd2, 1'b1},
        {1'b0, 8'h05, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 3'd4, 4'd6, 1'b0},
        {1'b1, 8'hA4, 8'h05, 3'd4, 1'b1, 1'b1, 1'b1, 3'd4, 4'd7, 1'b0},
        {1'b0, 8'h04, 8'h65, 3'd0, 1'b0, 1'b1, 1'b1, 3'd4, 4'd7, 1'b0}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Offer one byte at a falling edge and hold it until taken.
    task automatic put(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Wait for a result without accepting it.
    task automatic wait_result();
        while (!out_valid) @(negedge clk);
    endtask

    // Accept the pending result.
    task automatic take_result();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "in_ready", int'(in_ready), 1);

        // R2 foreign bytes are dropped
        put(8'h90); put(8'h48); put(8'h25);
        repeat (4) @(negedge clk);
        check("R2", "out_valid after foreign bytes", int'(out_valid), 0);
        check("R2", "in_ready after foreign bytes", int'(in_ready), 1);

        // Table walk; displacement bytes are 0xFF to test R9 alignment
        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            v = VEC[i];
            if (i % 2 == 1) put(8'h90);
            rex_w = v[30];
            put(8'hFF);
            rex_w = ~v[30];
            put(v[29:22]);
            if (v[8]) put(v[21:14]);
            for (int d = 0; d < int'(v[7:5]); d++) put(8'hFF);
            wait_result();
            check("R3", "op", int'(out_op), int'(v[13:11]));
            check("R5", "size64", int'(out_size64), int'(v[10]));
            check("R6", "is_mem", int'(out_is_mem), int'(v[9]));
            check("R7", "has_sib", int'(out_has_sib), int'(v[8]));
            check("R8", "disp_len", int'(out_disp_len), int'(v[7:5]));
            check("R9", "len", int'(out_len), int'(v[4:1]));
            check("R10", "illegal", int'(out_illegal), int'(v[0]));
            if (i == 0) check("R4", "near jump FF 25 len", int'(out_len), 6);
            take_result();
        end

        // R11 stall: result held, input blocked, next opcode waiting
        rex_w = 1'b0;
        put(8'hFF); put(8'h25);
        for (int d = 0; d < 4; d++) put(8'hFF);
        wait_result();
        in_valid = 1'b1;
        in_byte  = 8'hFF;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R11", "out_valid during stall", int'(out_valid), 1);
            check("R11", "in_ready during stall", int'(in_ready), 0);
            check("R11", "op held", int'(out_op), 4);
            check("R11", "len held", int'(out_len), 6);
        end
        // R12 release with the next byte already offered
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R12", "out_valid after accept", int'(out_valid), 0);
        check("R12", "in_ready after accept", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        put(8'hC0);
        wait_result();
        check("R12", "next op after overlap", int'(out_op), 0);
        check("R12", "next len after overlap", int'(out_len), 2);
        take_result();

        // R9 a following 0x90 byte after a short form is dropped, not decoded
        put(8'h90);
        repeat (2) @(negedge clk);
        check("R9", "no result from trailing byte", int'(out_valid), 0);

        finish_run();
    end

endmodule